// File: doc/BRIEF.md
# Upstream Bridge Request Reflector

This block terminates the upstream end of a chain of point-to-point packet links. Read and write requests that travel upstream from the devices below are decoded by their 40-bit byte address, of which only the doubleword part (address bits 39 to 2) travels on the ports. Requests that fall inside one of the downstream device windows are peer traffic. Devices below ignore upstream requests, so the bridge turns these around and re-sends them downstream, where the target claims them. All other requests go to the host side, tagged with a class that says whether they hit the fixed processor I/O window, the fixed configuration window, or ordinary host memory.

Requests that expect an answer (reads, and writes not marked posted) are recorded by their 5-bit source tag. Responses arrive from two sides: from a peer target travelling upstream, or from the host. A response whose tag is outstanding is sent downstream to the requester, and its entry is freed. A response with no matching entry is swallowed and latches an error flag. Every port uses a valid/ready handshake, and each output delivers packets in the order the bridge accepted them.

Top module: `ubr_reflector`

## Requirements
- R1: A byte address in FD_FC00_0000h..FD_FDFF_FFFFh goes to the host port with class 1 (I/O), and one in FD_FE00_0000h..FD_FFFF_FFFFh goes there with class 2 (configuration). This holds even when an enabled peer window also covers the address.
- R2: An address outside both fixed windows that lies within an enabled peer window (base <= doubleword address <= limit, both bounds inclusive, in doubleword units) leaves on the downstream request port with address, write, posted, tag and data unchanged. A disabled window never matches.
- R3: Any other address goes to the host port with class 0 (host memory), with all fields unchanged. Class 3 never appears on the host port.
- R4: Each request output is a FIFO of FIFO_DEPTH entries that keeps acceptance order. When the FIFO for a request's destination is full, the upstream ready is low. A full FIFO on one destination does not stall requests for the other.
- R5: A request is non-posted unless it is a write with the posted flag set; a read with the posted flag set is still non-posted. A non-posted request whose tag is already outstanding is held off (ready low) until a response for that tag has been accepted. Posted writes are never recorded and never wait on a tag.
- R6: A response whose tag is outstanding is sent on the downstream response port with the same tag, and its entry is freed. The read flag is 1 when the original request was a read; the data passes unchanged for a read and is all zero for a write.
- R7: A response whose tag is not outstanding is accepted, produces no output, and sets the error flag. The flag stays set until reset.
- R8: When both response inputs are valid in the same cycle, the peer-side response is served first, and the host-side ready is low in that cycle.
- R9: After reset, all output valids and the error flag are low, no tag is outstanding, and the upstream request ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| win_base_i | input | NWIN*(ADDR_W-2) | Doubleword base of each peer window, window 0 in the low bits |
| win_limit_i | input | NWIN*(ADDR_W-2) | Inclusive doubleword limit of each peer window |
| win_en_i | input | NWIN | Enable for each peer window |
| up_req_valid_i | input | 1 | Upstream request valid |
| up_req_ready_o | output | 1 | Upstream request ready |
| up_req_addr_i | input | ADDR_W-2 | Doubleword address (byte address bits 39..2) |
| up_req_write_i | input | 1 | 1 = write, 0 = read |
| up_req_posted_i | input | 1 | Posted flag (only meaningful for writes) |
| up_req_tag_i | input | TAG_W | Source tag |
| up_req_data_i | input | DATA_W | Write data |
| dn_req_valid_o | output | 1 | Reflected request valid |
| dn_req_ready_i | input | 1 | Reflected request ready |
| dn_req_addr_o | output | ADDR_W-2 | Reflected address |
| dn_req_write_o | output | 1 | Reflected write flag |
| dn_req_posted_o | output | 1 | Reflected posted flag |
| dn_req_tag_o | output | TAG_W | Reflected tag |
| dn_req_data_o | output | DATA_W | Reflected data |
| host_req_valid_o | output | 1 | Host request valid |
| host_req_ready_i | input | 1 | Host request ready |
| host_req_addr_o | output | ADDR_W-2 | Host request address |
| host_req_write_o | output | 1 | Host request write flag |
| host_req_posted_o | output | 1 | Host request posted flag |
| host_req_tag_o | output | TAG_W | Host request tag |
| host_req_data_o | output | DATA_W | Host request data |
| host_req_cls_o | output | 2 | 0 memory, 1 I/O, 2 configuration |
| peer_rsp_valid_i | input | 1 | Response from a peer target, valid |
| peer_rsp_ready_o | output | 1 | Peer response ready |
| peer_rsp_tag_i | input | TAG_W | Peer response tag |
| peer_rsp_data_i | input | DATA_W | Peer response data |
| host_rsp_valid_i | input | 1 | Response from the host, valid |
| host_rsp_ready_o | output | 1 | Host response ready |
| host_rsp_tag_i | input | TAG_W | Host response tag |
| host_rsp_data_i | input | DATA_W | Host response data |
| dn_rsp_valid_o | output | 1 | Response to requester, valid |
| dn_rsp_ready_i | input | 1 | Response to requester, ready |
| dn_rsp_tag_o | output | TAG_W | Response tag |
| dn_rsp_read_o | output | 1 | 1 when the response answers a read |
| dn_rsp_data_o | output | DATA_W | Response data (zero for writes) |
| rsp_err_o | output | 1 | Sticky flag: an unmatched response was dropped |

## Verification
The decode is tried with addresses at both edges of each peer window and each fixed window, with a disabled window, and with a peer window that overlaps the fixed windows. This separates off-by-one bound errors, enable errors and priority errors. Tag tracking is tried with reads, non-posted writes, reads marked posted and posted writes that reuse a busy tag. A stall that should not happen, or a response where the read flag or data mask is wrong, shows up on its own. Back-pressure on one output while the other keeps flowing, and two responses offered in the same cycle, show whether order and priority are kept.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
  typedef enum logic [1:0] {
    CLS_MEM  = 2'd0,
    CLS_IO   = 2'd1,
    CLS_CFG  = 2'd2,
    CLS_PEER = 2'd3
  } ubr_cls_e;
endpackage

// File: rtl/ubr_decode.sv
module ubr_decode
  import ubr_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int NWIN   = 4,
  parameter logic [ADDR_W-1:0] IO_LO  = 40'hFD_FC00_0000,
  parameter logic [ADDR_W-1:0] IO_HI  = 40'hFD_FDFF_FFFF,
  parameter logic [ADDR_W-1:0] CFG_LO = 40'hFD_FE00_0000,
  parameter logic [ADDR_W-1:0] CFG_HI = 40'hFD_FFFF_FFFF
) (
  input  logic [ADDR_W-3:0]      addr_i,
  input  logic [NWIN*(ADDR_W-2)-1:0] base_i,
  input  logic [NWIN*(ADDR_W-2)-1:0] limit_i,
  input  logic [NWIN-1:0]        en_i,
  output ubr_cls_e               cls_o
);
  localparam int DW_W = ADDR_W - 2;
  localparam logic [DW_W-1:0] IO_LO_DW  = IO_LO[ADDR_W-1:2];
  localparam logic [DW_W-1:0] IO_HI_DW  = IO_HI[ADDR_W-1:2];
  localparam logic [DW_W-1:0] CFG_LO_DW = CFG_LO[ADDR_W-1:2];
  localparam logic [DW_W-1:0] CFG_HI_DW = CFG_HI[ADDR_W-1:2];

  logic [NWIN-1:0] hit;
  logic in_io, in_cfg;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [DW_W-1:0] lo, hi;
    assign lo     = base_i[i*DW_W +: DW_W];
    assign hi     = limit_i[i*DW_W +: DW_W];
    assign hit[i] = en_i[i] && (addr_i >= lo) && (addr_i <= hi);
  end

  assign in_io  = (addr_i >= IO_LO_DW)  && (addr_i <= IO_HI_DW);
  assign in_cfg = (addr_i >= CFG_LO_DW) && (addr_i <= CFG_HI_DW);

  // fixed windows outrank programmed peer windows
  always_comb begin
    if (in_io)       cls_o = CLS_IO;
    else if (in_cfg) cls_o = CLS_CFG;
    else if (|hit)   cls_o = CLS_PEER;
    else             cls_o = CLS_MEM;
  end
endmodule

// File: rtl/ubr_fifo.sv
module ubr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] wdata_i,
  input  logic         pop_i,
  output logic [W-1:0] rdata_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign empty_o = (cnt_q == '0);

  // R4
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R4
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/ubr_tag_table.sv
module ubr_tag_table #(
  parameter int TAG_W = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  set_en_i,
  input  logic [TAG_W-1:0]      set_tag_i,
  input  logic                  set_read_i,
  input  logic                  clr_en_i,
  input  logic [TAG_W-1:0]      clr_tag_i,
  output logic [(1<<TAG_W)-1:0] busy_o,
  output logic [(1<<TAG_W)-1:0] read_o
);
  localparam int NTAG = 1 << TAG_W;

  for (genvar i = 0; i < NTAG; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_o[i] <= 1'b0;
        read_o[i] <= 1'b0;
      end else if (set_en_i && set_tag_i == TAG_W'(i)) begin
        busy_o[i] <= 1'b1;
        read_o[i] <= set_read_i;
      end else if (clr_en_i && clr_tag_i == TAG_W'(i)) begin
        busy_o[i] <= 1'b0;
      end
    end
  end

  // R5
  set_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |-> !busy_o[set_tag_i]);
  // R6
  clr_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_en_i |-> busy_o[clr_tag_i]);
endmodule

// File: rtl/ubr_reflector.sv
module ubr_reflector
  import ubr_pkg::*;
#(
  parameter int ADDR_W     = 40,
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 5,
  parameter int NWIN       = 4,
  parameter int FIFO_DEPTH = 4,
  parameter logic [ADDR_W-1:0] IO_LO  = 40'hFD_FC00_0000,
  parameter logic [ADDR_W-1:0] IO_HI  = 40'hFD_FDFF_FFFF,
  parameter logic [ADDR_W-1:0] CFG_LO = 40'hFD_FE00_0000,
  parameter logic [ADDR_W-1:0] CFG_HI = 40'hFD_FFFF_FFFF
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NWIN*(ADDR_W-2)-1:0] win_base_i,
  input  logic [NWIN*(ADDR_W-2)-1:0] win_limit_i,
  input  logic [NWIN-1:0]            win_en_i,
  input  logic                       up_req_valid_i,
  output logic                       up_req_ready_o,
  input  logic [ADDR_W-3:0]          up_req_addr_i,
  input  logic                       up_req_write_i,
  input  logic                       up_req_posted_i,
  input  logic [TAG_W-1:0]           up_req_tag_i,
  input  logic [DATA_W-1:0]          up_req_data_i,
  output logic                       dn_req_valid_o,
  input  logic                       dn_req_ready_i,
  output logic [ADDR_W-3:0]          dn_req_addr_o,
  output logic                       dn_req_write_o,
  output logic                       dn_req_posted_o,
  output logic [TAG_W-1:0]           dn_req_tag_o,
  output logic [DATA_W-1:0]          dn_req_data_o,
  output logic                       host_req_valid_o,
  input  logic                       host_req_ready_i,
  output logic [ADDR_W-3:0]          host_req_addr_o,
  output logic                       host_req_write_o,
  output logic                       host_req_posted_o,
  output logic [TAG_W-1:0]           host_req_tag_o,
  output logic [DATA_W-1:0]          host_req_data_o,
  output logic [1:0]                 host_req_cls_o,
  input  logic                       peer_rsp_valid_i,
  output logic                       peer_rsp_ready_o,
  input  logic [TAG_W-1:0]           peer_rsp_tag_i,
  input  logic [DATA_W-1:0]          peer_rsp_data_i,
  input  logic                       host_rsp_valid_i,
  output logic                       host_rsp_ready_o,
  input  logic [TAG_W-1:0]           host_rsp_tag_i,
  input  logic [DATA_W-1:0]          host_rsp_data_i,
  output logic                       dn_rsp_valid_o,
  input  logic                       dn_rsp_ready_i,
  output logic [TAG_W-1:0]           dn_rsp_tag_o,
  output logic                       dn_rsp_read_o,
  output logic [DATA_W-1:0]          dn_rsp_data_o,
  output logic                       rsp_err_o
);
  localparam int DW_W   = ADDR_W - 2;
  localparam int NTAG   = 1 << TAG_W;
  localparam int REQ_W  = DW_W + 2 + TAG_W + DATA_W;
  localparam int HREQ_W = REQ_W + 2;
  localparam int RSP_W  = TAG_W + 1 + DATA_W;

  // ---------------- request path ----------------
  ubr_cls_e        req_cls;
  logic            to_peer, req_np, req_acc;
  logic            dn_full, dn_empty, host_full, host_empty, rsp_full, rsp_empty;
  logic [NTAG-1:0] tag_busy, tag_rd;
  logic [REQ_W-1:0]  req_word, dn_word;
  logic [HREQ_W-1:0] host_word;

  ubr_decode #(
    .ADDR_W(ADDR_W), .NWIN(NWIN),
    .IO_LO(IO_LO), .IO_HI(IO_HI), .CFG_LO(CFG_LO), .CFG_HI(CFG_HI)
  ) u_decode (
    .addr_i (up_req_addr_i),
    .base_i (win_base_i),
    .limit_i(win_limit_i),
    .en_i   (win_en_i),
    .cls_o  (req_cls)
  );

  assign to_peer = (req_cls == CLS_PEER);
  assign req_np  = !(up_req_write_i && up_req_posted_i);
  assign up_req_ready_o = !(to_peer ? dn_full : host_full) &&
                          !(req_np && tag_busy[up_req_tag_i]);
  assign req_acc  = up_req_valid_i && up_req_ready_o;
  assign req_word = {up_req_addr_i, up_req_write_i, up_req_posted_i,
                     up_req_tag_i, up_req_data_i};

  ubr_fifo #(.W(REQ_W), .DEPTH(FIFO_DEPTH)) u_dn_q (
    .clk_i, .rst_ni,
    .push_i (req_acc && to_peer),
    .wdata_i(req_word),
    .pop_i  (dn_req_valid_o && dn_req_ready_i),
    .rdata_o(dn_word),
    .full_o (dn_full),
    .empty_o(dn_empty)
  );

  ubr_fifo #(.W(HREQ_W), .DEPTH(FIFO_DEPTH)) u_host_q (
    .clk_i, .rst_ni,
    .push_i (req_acc && !to_peer),
    .wdata_i({req_cls, req_word}),
    .pop_i  (host_req_valid_o && host_req_ready_i),
    .rdata_o(host_word),
    .full_o (host_full),
    .empty_o(host_empty)
  );

  assign dn_req_valid_o = !dn_empty;
  assign {dn_req_addr_o, dn_req_write_o, dn_req_posted_o,
          dn_req_tag_o, dn_req_data_o} = dn_word;

  assign host_req_valid_o = !host_empty;
  assign {host_req_cls_o, host_req_addr_o, host_req_write_o, host_req_posted_o,
          host_req_tag_o, host_req_data_o} = host_word;

  // ---------------- response path ----------------
  logic              rsp_acc, rsp_hit, rsp_push, rsp_rd, err_q;
  logic [TAG_W-1:0]  rsp_tag;
  logic [DATA_W-1:0] rsp_data;
  logic [RSP_W-1:0]  rsp_word;

  // peer side has fixed priority
  assign peer_rsp_ready_o = !(tag_busy[peer_rsp_tag_i] && rsp_full);
  assign host_rsp_ready_o = !peer_rsp_valid_i &&
                            !(tag_busy[host_rsp_tag_i] && rsp_full);

  assign rsp_tag  = peer_rsp_valid_i ? peer_rsp_tag_i  : host_rsp_tag_i;
  assign rsp_data = peer_rsp_valid_i ? peer_rsp_data_i : host_rsp_data_i;
  assign rsp_acc  = (peer_rsp_valid_i && peer_rsp_ready_o) ||
                    (host_rsp_valid_i && host_rsp_ready_o);
  assign rsp_hit  = tag_busy[rsp_tag];
  assign rsp_rd   = tag_rd[rsp_tag];
  assign rsp_push = rsp_acc && rsp_hit;

  ubr_tag_table #(.TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni,
    .set_en_i  (req_acc && req_np),
    .set_tag_i (up_req_tag_i),
    .set_read_i(!up_req_write_i),
    .clr_en_i  (rsp_push),
    .clr_tag_i (rsp_tag),
    .busy_o    (tag_busy),
    .read_o    (tag_rd)
  );

  ubr_fifo #(.W(RSP_W), .DEPTH(FIFO_DEPTH)) u_rsp_q (
    .clk_i, .rst_ni,
    .push_i (rsp_push),
    .wdata_i({rsp_tag, rsp_rd, rsp_rd ? rsp_data : '0}),
    .pop_i  (dn_rsp_valid_o && dn_rsp_ready_i),
    .rdata_o(rsp_word),
    .full_o (rsp_full),
    .empty_o(rsp_empty)
  );

  assign dn_rsp_valid_o = !rsp_empty;
  assign {dn_rsp_tag_o, dn_rsp_read_o, dn_rsp_data_o} = rsp_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  err_q <= 1'b0;
    else if (rsp_acc && !rsp_hit) err_q <= 1'b1;
  end
  assign rsp_err_o = err_q;

  // R5
  np_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_acc && req_np) |=> tag_busy[$past(up_req_tag_i)]);
  // R6
  rsp_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_push |=> !tag_busy[$past(rsp_tag)]);
  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |=> rsp_err_o);
  // R8
  rsp_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    peer_rsp_valid_i |-> !host_rsp_ready_o);
  // R6
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_rsp_valid_o && !dn_rsp_ready_i) |=> (dn_rsp_valid_o && $stable(dn_rsp_tag_o)));
  // R3
  host_cls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_req_valid_o |-> (host_req_cls_o != CLS_PEER));
endmodule

// File: tb/tb_ubr_reflector.sv
`timescale 1ns/1ps
module tb_ubr_reflector;
  localparam int DW_W = 38;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [4*DW_W-1:0] win_base, win_limit;
  logic [3:0]        win_en;
  logic              up_valid = 0, up_ready, up_write = 0, up_posted = 0;
  logic [DW_W-1:0]   up_addr = '0;
  logic [4:0]        up_tag = '0;
  logic [31:0]       up_data = '0;
  logic              dn_valid, dn_ready = 0, dn_write, dn_posted;
  logic [DW_W-1:0]   dn_addr;
  logic [4:0]        dn_tag;
  logic [31:0]       dn_data;
  logic              h_valid, h_ready = 0, h_write, h_posted;
  logic [DW_W-1:0]   h_addr;
  logic [4:0]        h_tag;
  logic [31:0]       h_data;
  logic [1:0]        h_cls;
  logic              p_rv = 0, p_rr, h_rv = 0, h_rr;
  logic [4:0]        p_rt = '0, h_rt = '0;
  logic [31:0]       p_rd = '0, h_rd = '0;
  logic              r_valid, r_ready = 0, r_read, err;
  logic [4:0]        r_tag;
  logic [31:0]       r_data;

  ubr_reflector dut (
    .clk_i(clk), .rst_ni(rst_n),
    .win_base_i(win_base), .win_limit_i(win_limit), .win_en_i(win_en),
    .up_req_valid_i(up_valid), .up_req_ready_o(up_ready), .up_req_addr_i(up_addr),
    .up_req_write_i(up_write), .up_req_posted_i(up_posted), .up_req_tag_i(up_tag),
    .up_req_data_i(up_data),
    .dn_req_valid_o(dn_valid), .dn_req_ready_i(dn_ready), .dn_req_addr_o(dn_addr),
    .dn_req_write_o(dn_write), .dn_req_posted_o(dn_posted), .dn_req_tag_o(dn_tag),
    .dn_req_data_o(dn_data),
    .host_req_valid_o(h_valid), .host_req_ready_i(h_ready), .host_req_addr_o(h_addr),
    .host_req_write_o(h_write), .host_req_posted_o(h_posted), .host_req_tag_o(h_tag),
    .host_req_data_o(h_data), .host_req_cls_o(h_cls),
    .peer_rsp_valid_i(p_rv), .peer_rsp_ready_o(p_rr), .peer_rsp_tag_i(p_rt),
    .peer_rsp_data_i(p_rd),
    .host_rsp_valid_i(h_rv), .host_rsp_ready_o(h_rr), .host_rsp_tag_i(h_rt),
    .host_rsp_data_i(h_rd),
    .dn_rsp_valid_o(r_valid), .dn_rsp_ready_i(r_ready), .dn_rsp_tag_o(r_tag),
    .dn_rsp_read_o(r_read), .dn_rsp_data_o(r_data), .rsp_err_o(err)
  );

  typedef struct { logic [127:0] v; string rq; } exp_t;
  exp_t exp_dn[$], exp_host[$], exp_rsp[$];
  bit   outst[32];
  bit   outst_rd[32];
  int   n_chk = 0, n_fail = 0;
  int   cyc = 0;
  bit   hold_dn = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [127:0] act, input logic [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  // monitor: ready patterns and scoreboard compare
  always @(negedge clk) begin
    if (rst_n) begin
      exp_t e;
      logic [127:0] a;
      cyc++;
      dn_ready = !hold_dn && (cyc % 3 != 0);
      h_ready  = (cyc % 4 != 1);
      r_ready  = (cyc % 5 != 2);
      if (dn_valid && dn_ready) begin
        a = 128'({dn_addr, dn_write, dn_posted, dn_tag, dn_data});
        if (exp_dn.size() == 0) chk(0, "R2", "unexpected reflected request", a, 0);
        else begin e = exp_dn.pop_front(); chk(a == e.v, e.rq, "reflected request", a, e.v); end
      end
      if (h_valid && h_ready) begin
        a = 128'({h_cls, h_addr, h_write, h_posted, h_tag, h_data});
        if (exp_host.size() == 0) chk(0, "R3", "unexpected host request", a, 0);
        else begin e = exp_host.pop_front(); chk(a == e.v, e.rq, "host request", a, e.v); end
      end
      if (r_valid && r_ready) begin
        a = 128'({r_tag, r_read, r_data});
        if (exp_rsp.size() == 0) chk(0, "R7", "unexpected response", a, 0);
        else begin e = exp_rsp.pop_front(); chk(a == e.v, e.rq, "response", a, e.v); end
      end
    end
  end

  task automatic send_req(input logic [39:0] ba, input bit wr, input bit po,
                          input logic [4:0] tag, input logic [31:0] d,
                          input bit peer, input logic [1:0] cls,
                          input string rq, output int waits);
    exp_t e;
    waits = 0;
    @(negedge clk);
    up_valid = 1; up_addr = ba[39:2]; up_write = wr; up_posted = po;
    up_tag = tag; up_data = d;
    #1;
    while (!up_ready) begin @(negedge clk); #1; waits++; end
    e.rq = rq;
    if (peer) begin
      e.v = 128'({ba[39:2], wr, po, tag, d});
      exp_dn.push_back(e);
    end else begin
      e.v = 128'({cls, ba[39:2], wr, po, tag, d});
      exp_host.push_back(e);
    end
    if (!(wr && po)) begin outst[tag] = 1; outst_rd[tag] = !wr; end
    @(posedge clk); #1;
    up_valid = 0;
  endtask

  task automatic req(input logic [39:0] ba, input bit wr, input bit po,
                     input logic [4:0] tag, input logic [31:0] d,
                     input bit peer, input logic [1:0] cls, input string rq);
    int w;
    send_req(ba, wr, po, tag, d, peer, cls, rq, w);
  endtask

  // offer a request that must stay stalled for n cycles, then withdraw it
  task automatic try_stall(input logic [39:0] ba, input bit wr, input bit po,
                           input logic [4:0] tag, input int n, input string rq);
    @(negedge clk);
    up_valid = 1; up_addr = ba[39:2]; up_write = wr; up_posted = po; up_tag = tag;
    for (int k = 0; k < n; k++) begin
      #1;
      chk(up_ready == 0, rq, "request must stall", 128'(up_ready), 0);
      @(negedge clk);
    end
    up_valid = 0;
  endtask

  task automatic push_rsp(input logic [4:0] tag, input logic [31:0] d, input string rq);
    exp_t e;
    e.rq = rq;
    e.v  = 128'({tag, outst_rd[tag], outst_rd[tag] ? d : 32'h0});
    exp_rsp.push_back(e);
    outst[tag] = 0;
  endtask

  task automatic send_rsp(input bit from_peer, input logic [4:0] tag,
                          input logic [31:0] d, input string rq);
    bit hit;
    @(negedge clk);
    if (from_peer) begin p_rv = 1; p_rt = tag; p_rd = d; end
    else           begin h_rv = 1; h_rt = tag; h_rd = d; end
    #1;
    while (!(from_peer ? p_rr : h_rr)) begin @(negedge clk); #1; end
    hit = outst[tag];
    if (hit) push_rsp(tag, d, rq);
    @(posedge clk); #1;
    p_rv = 0; h_rv = 0;
    if (!hit) chk(err == 1, rq, "unmatched response sets error", 128'(err), 1);
  endtask

  function automatic logic [DW_W-1:0] dw(input logic [39:0] a);
    return a[39:2];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WATCHDOG", "run did not finish", 0, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int w;
    win_base  = {dw(40'hFD_F000_0000), dw(40'h02_0000_0000),
                 dw(40'h01_0000_0000), dw(40'h00_8000_0000)};
    win_limit = {dw(40'hFD_FFFF_FFFF), dw(40'h02_FFFF_FFFF),
                 dw(40'h01_0000_FFFF), dw(40'h00_8FFF_FFFF)};
    win_en    = 4'b1011;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    // R9 reset state
    chk(up_ready == 1, "R9", "ready after reset", 128'(up_ready), 1);
    chk({dn_valid, h_valid, r_valid} == 0, "R9", "valids after reset",
        128'({dn_valid, h_valid, r_valid}), 0);
    chk(err == 0, "R9", "error flag after reset", 128'(err), 0);

    // R3 host memory, incl. window edges and disabled window (R2)
    req(40'h00_0000_1000, 0, 0, 5'd1, 32'h0,         0, 2'd0, "R3");
    req(40'h00_7FFF_FFFC, 1, 1, 5'd0, 32'h1111_0001, 0, 2'd0, "R3");
    req(40'h00_9000_0000, 1, 1, 5'd0, 32'h1111_0002, 0, 2'd0, "R3");
    req(40'h02_0000_0000, 1, 1, 5'd0, 32'h1111_0003, 0, 2'd0, "R2");
    // R2 peer windows, both edges
    req(40'h00_8000_0000, 1, 1, 5'd0, 32'h2222_0001, 1, 2'd0, "R2");
    req(40'h00_8FFF_FFFC, 0, 0, 5'd2, 32'h0,         1, 2'd0, "R2");
    req(40'h01_0000_0010, 1, 1, 5'd0, 32'h2222_0002, 1, 2'd0, "R2");
    req(40'h01_0000_FFFC, 1, 1, 5'd0, 32'h2222_0003, 1, 2'd0, "R2");
    req(40'hFD_FBFF_FFFC, 1, 1, 5'd0, 32'h2222_0004, 1, 2'd0, "R2");
    // R1 fixed windows override overlapping peer window
    req(40'hFD_FC00_0000, 0, 0, 5'd4, 32'h0,         0, 2'd1, "R1");
    req(40'hFD_FDFF_FFFC, 1, 1, 5'd0, 32'h3333_0001, 0, 2'd1, "R1");
    req(40'hFD_FE00_0000, 0, 0, 5'd5, 32'h0,         0, 2'd2, "R1");
    req(40'hFD_FFFF_FFFC, 1, 1, 5'd0, 32'h3333_0002, 0, 2'd2, "R1");

    // R6 matched responses
    send_rsp(0, 5'd1, 32'hA5A5_0001, "R6");
    send_rsp(1, 5'd2, 32'hA5A5_0002, "R6");
    send_rsp(0, 5'd4, 32'hA5A5_0004, "R6");
    send_rsp(0, 5'd5, 32'hA5A5_0005, "R6");
    req(40'h00_8000_0100, 1, 0, 5'd6, 32'h0000_1234, 1, 2'd0, "R6");
    send_rsp(1, 5'd6, 32'hFFFF_FFFF, "R6");

    // R5 tag stall, posted bypass, posted-read treated as non-posted
    req(40'h00_0000_2000, 0, 0, 5'd7, 32'h0, 0, 2'd0, "R5");
    try_stall(40'h00_0000_2004, 0, 0, 5'd7, 4, "R5");
    send_req(40'h00_0000_2008, 1, 1, 5'd7, 32'h5555_0001, 0, 2'd0, "R5", w);
    chk(w == 0, "R5", "posted write with busy tag waits", 128'(w), 0);
    send_rsp(0, 5'd7, 32'hA5A5_0007, "R5");
    req(40'h00_0000_2004, 0, 0, 5'd7, 32'h0, 0, 2'd0, "R5");
    send_rsp(0, 5'd7, 32'hA5A5_0017, "R5");
    req(40'h00_0000_3000, 0, 1, 5'd8, 32'h0, 0, 2'd0, "R5");
    try_stall(40'h00_0000_3004, 1, 0, 5'd8, 3, "R5");
    send_rsp(0, 5'd8, 32'hA5A5_0008, "R5");

    // R7 unmatched responses
    send_rsp(1, 5'd20, 32'hDEAD_0001, "R7");
    send_rsp(0, 5'd7,  32'hDEAD_0002, "R7");
    repeat (5) @(negedge clk);
    chk(err == 1, "R7", "error flag stays set", 128'(err), 1);

    // R8 simultaneous responses
    req(40'h00_0000_4000, 0, 0, 5'd9,  32'h0, 0, 2'd0, "R8");
    req(40'h00_8000_4000, 0, 0, 5'd10, 32'h0, 1, 2'd0, "R8");
    repeat (10) @(negedge clk);
    @(negedge clk);
    p_rv = 1; p_rt = 5'd10; p_rd = 32'hB0B0_000A;
    h_rv = 1; h_rt = 5'd9;  h_rd = 32'hB0B0_0009;
    #1;
    chk(p_rr == 1, "R8", "peer response ready", 128'(p_rr), 1);
    chk(h_rr == 0, "R8", "host response held off", 128'(h_rr), 0);
    push_rsp(5'd10, 32'hB0B0_000A, "R8");
    @(posedge clk); #1;
    p_rv = 0;
    @(negedge clk); #1;
    while (!h_rr) begin @(negedge clk); #1; end
    push_rsp(5'd9, 32'hB0B0_0009, "R8");
    @(posedge clk); #1;
    h_rv = 0;

    // R4 back-pressure on reflected path only
    repeat (10) @(negedge clk);
    hold_dn = 1;
    for (int k = 0; k < 4; k++)
      req(40'h00_8000_5000 + 40'(k*4), 1, 1, 5'd0, 32'h4444_0000 + k, 1, 2'd0, "R4");
    try_stall(40'h00_8000_5010, 1, 1, 5'd0, 3, "R4");
    send_req(40'h00_0000_5000, 1, 1, 5'd0, 32'h4444_00FF, 0, 2'd0, "R4", w);
    chk(w == 0, "R4", "host path flows while reflected path full", 128'(w), 0);
    hold_dn = 0;
    req(40'h00_8000_5010, 1, 1, 5'd0, 32'h4444_0004, 1, 2'd0, "R4");

    repeat (30) @(negedge clk);
    chk(exp_dn.size() == 0, "R4", "reflected queue drained", 128'(exp_dn.size()), 0);
    chk(exp_host.size() == 0, "R4", "host queue drained", 128'(exp_host.size()), 0);
    chk(exp_rsp.size() == 0, "R6", "responses drained", 128'(exp_rsp.size()), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule